// File: doc/BRIEF.md
# Programmable External PHY Reset Driver

This block generates the reset signal for an external Ethernet PHY that has no power-on reset circuit of its own. Software controls it through four fields, which reach the block as plain inputs. A polarity bit selects whether the pin is active-high or active-low. A level bit holds the pin asserted for as long as it is set. A pulse-trigger strobe starts a reset pulse that ends by itself. An 8-bit width field sets the pulse length.

The pulse length is measured in ticks of an internal prescaler. The prescaler restarts on every trigger, so the pulse length does not depend on the phase of a free-running divider. The trigger is a one-cycle strobe. Software never needs to clear it, because the timer counts down and releases the pin unaided. A status output shows when a timed pulse is still running.

Top module: `phy_rst_drv`

## Requirements
- R1: While `rst_n` is low, and after it is released, the internal assert state is clear, no pulse is running, `pulse_busy_o` is 0, and the polarity register reads 0 (active-low). So `phy_rst_o` sits at 1.
- R2: `phy_rst_o` equals the internal assert state when the registered polarity is 1, and its inverse when the registered polarity is 0. A change on `cfg_act_high` shows on the pin one cycle after the edge that samples it.
- R3: While the registered level bit is 1, the pin is at its asserted value. `cfg_level_rst` takes effect one cycle after the edge that samples it.
- R4: A strobe on `cfg_pulse_go` with width W > 0 asserts the pin for exactly W × TICK_DIV clock cycles, starting in the cycle after the sampling edge. The pin then releases with no further input.
- R5: A strobe with width 0 starts no pulse. If a pulse is already running, such a strobe ends it at the next edge.
- R6: A strobe during a running pulse reloads the timer with the width present at that strobe. The remaining time becomes that width × TICK_DIV cycles, counted from the new strobe.
- R7: When the level bit and a timed pulse are both active, the pin carries their OR. Clearing the level bit does not cut short a running pulse, and an ending pulse does not release a set level bit.
- R8: `pulse_busy_o` is 1 exactly while a timed pulse is running, whatever the level bit and polarity are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| cfg_act_high | input | 1 | Polarity select: 1 = active-high pin, 0 = active-low pin |
| cfg_level_rst | input | 1 | Level-mode reset request; holds the pin asserted while 1 |
| cfg_pulse_go | input | 1 | One-cycle strobe that starts or reloads a timed pulse |
| cfg_pulse_width | input | WIDTH_BITS | Pulse length in prescaler ticks |
| phy_rst_o | output | 1 | Reset pin to the external PHY |
| pulse_busy_o | output | 1 | 1 while a timed pulse is running |

## Verification
The bench builds the block with TICK_DIV = 4 and keeps the default 8-bit width field. This keeps every pulse under roughly a thousand cycles. The bench can therefore measure whole pulses, including the largest widths, and can land retriggers and zero-width strobes at every phase of the prescaler. The random phase draws widths of 0 to 6 ticks. It overlaps strobes, level requests and polarity flips often, so the cycle-accurate reference model meets every interaction between the two modes.

// File: rtl/phyrst_pkg.sv
package phyrst_pkg;

   // Bits needed to count 0 .. n-1 (at least one bit).
   function automatic int unsigned cnt_bits(int unsigned n);
      int unsigned b;
      b = 1;
      while ((32'd1 << b) < n) b++;
      return b;
   endfunction

   typedef enum logic {
      POL_ACT_LOW  = 1'b0,
      POL_ACT_HIGH = 1'b1
   } pin_pol_e;

endpackage

// File: rtl/phyrst_tick_gen.sv
module phyrst_tick_gen #(
   parameter int unsigned TICK_DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   import phyrst_pkg::*;

   localparam int unsigned CW = cnt_bits(TICK_DIV);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("phyrst_tick_gen: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_bypass
      // Every cycle is a tick except the one that restarts the time base.
      assign tick = ~restart;
   end else begin : g_divide
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              div_q <= '0;
         else if (restart)        div_q <= '0;
         else if (div_q == LAST)  div_q <= '0;
         else                     div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST) && !restart;

      // R4
      presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
         restart |=> (div_q == '0));

      // R4
      presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!restart && div_q == LAST) |=> (div_q == '0));
   end

endmodule

// File: rtl/phyrst_pulse_timer.sv
module phyrst_pulse_timer #(
   parameter int unsigned WIDTH_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [WIDTH_BITS-1:0] width,
   input  logic                  tick,
   output logic                  busy
);

   if (WIDTH_BITS < 1 || WIDTH_BITS > 16) begin : g_bad_width
      $error("phyrst_pulse_timer: WIDTH_BITS must be 1..16");
   end

   logic [WIDTH_BITS-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      left_q <= '0;
      else if (go)                     left_q <= width;
      else if (tick && left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

   // R6
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (left_q == $past(width)));

   // R5
   zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && width == '0) |=> !busy);

   // R4
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(tick) || $past(go)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && !tick) |=> $stable(left_q));

endmodule

// File: rtl/phyrst_pin_stage.sv
module phyrst_pin_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic act_high_in,
   input  logic level_in,
   input  logic pulse_busy,
   output logic pin
);
   import phyrst_pkg::*;

   pin_pol_e pol_q;
   logic     level_q;
   logic     assert_int;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q   <= POL_ACT_LOW;
         level_q <= 1'b0;
      end else begin
         pol_q   <= pin_pol_e'(act_high_in);
         level_q <= level_in;
      end
   end

   assign assert_int = level_q | pulse_busy;
   assign pin        = assert_int ^ (pol_q == POL_ACT_LOW);

   // R3
   level_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(level_in) |-> (pin == $past(act_high_in)));

   // R8
   busy_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_busy |-> (pin == (pol_q == POL_ACT_HIGH)));

endmodule

// File: rtl/phy_rst_drv.sv
module phy_rst_drv #(
   parameter int unsigned TICK_DIV   = 256,
   parameter int unsigned WIDTH_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_act_high,
   input  logic                  cfg_level_rst,
   input  logic                  cfg_pulse_go,
   input  logic [WIDTH_BITS-1:0] cfg_pulse_width,
   output logic                  phy_rst_o,
   output logic                  pulse_busy_o
);

   logic tick;
   logic busy;

   phyrst_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_pulse_go),
      .tick    (tick)
   );

   phyrst_pulse_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (cfg_pulse_go),
      .width (cfg_pulse_width),
      .tick  (tick),
      .busy  (busy)
   );

   phyrst_pin_stage u_pin (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_high_in (cfg_act_high),
      .level_in    (cfg_level_rst),
      .pulse_busy  (busy),
      .pin         (phy_rst_o)
   );

   assign pulse_busy_o = busy;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      (!rst_n) |=> (!rst_n || (!pulse_busy_o && phy_rst_o)));

   // R7
   or_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_level_rst) || pulse_busy_o) |-> (phy_rst_o == $past(cfg_act_high)));

endmodule

// File: tb/test_phy_rst_drv.sv
`timescale 1ns/100ps
module test_phy_rst_drv;
   localparam int DIV = 4;
   localparam int WB  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          act_high = 1'b0;
   logic          lvl = 1'b0;
   logic          go = 1'b0;
   logic [WB-1:0] width = '0;
   logic          pin;
   logic          busy;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string req = "R1";

   // reference state derived from the requirements
   int rem = 0;
   bit m_lvl = 1'b0;
   bit m_pol = 1'b0;

   always #2.5 clk = ~clk;

   phy_rst_drv #(.TICK_DIV(DIV), .WIDTH_BITS(WB)) i_phy_rst_drv (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_act_high    (act_high),
      .cfg_level_rst   (lvl),
      .cfg_pulse_go    (go),
      .cfg_pulse_width (width),
      .phy_rst_o       (pin),
      .pulse_busy_o    (busy)
   );

   function automatic bit exp_pin();
      return (m_lvl || rem != 0) ^ !m_pol;
   endfunction

   task automatic chk(string r, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", r, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         rem = 0; m_lvl = 0; m_pol = 0;
      end else begin
         if (go)           rem = int'(width) * DIV;
         else if (rem > 0) rem = rem - 1;
         m_lvl = lvl;
         m_pol = act_high;
      end
   end

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({req, " R2 pin"}, pin, exp_pin());
         chk({req, " R8 busy"}, busy, rem != 0);
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic pulse_len(string r, int w, int exp_len);
      int len;
      len = 0;
      width = WB'(w);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      while (busy && len < 5000) begin
         len++;
         @(negedge clk);
      end
      chk_int(r, len, exp_len);
   endtask

   task automatic chk_int(string r, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      // R1: reset state
      idle(3);
      chk("R1 pin in reset", pin, 1'b1);
      chk("R1 busy in reset", busy, 1'b0);
      rst_n = 1'b1;
      idle(2);
      chk("R1 pin after reset", pin, 1'b1);

      // R3 level mode, active low then active high (R2)
      req = "R3";
      lvl = 1'b1;
      @(negedge clk);
      chk("R3 level asserts low", pin, 1'b0);
      idle(5);
      lvl = 1'b0;
      @(negedge clk);
      chk("R3 level release", pin, 1'b1);
      req = "R2";
      act_high = 1'b1;
      @(negedge clk);
      chk("R2 idle active-high", pin, 1'b0);
      lvl = 1'b1;
      @(negedge clk);
      chk("R2 asserted active-high", pin, 1'b1);
      lvl = 1'b0;
      idle(2);

      // R4 pulse lengths, including the largest width
      req = "R4";
      pulse_len("R4 width 1", 1, DIV);
      pulse_len("R4 width 3", 3, 3 * DIV);
      pulse_len("R4 width 255", 255, 255 * DIV);
      chk("R4 released", pin, 1'b0);

      // R5 zero width: no pulse, and cancel of a running one
      req = "R5";
      pulse_len("R5 width 0", 0, 0);
      width = 8'd9; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      idle(6);
      width = 8'd0; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk("R5 cancel ends pulse", busy, 1'b0);

      // R6 retrigger mid-pulse at an odd prescaler phase
      req = "R6";
      width = 8'd2; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      idle(5);
      pulse_len("R6 reload", 3, 3 * DIV);

      // R7 level and pulse overlap
      req = "R7";
      act_high = 1'b0;
      width = 8'd2; go = 1'b1; lvl = 1'b1;
      @(negedge clk);
      go = 1'b0;
      idle(2);
      lvl = 1'b0;
      @(negedge clk);
      chk("R7 pulse survives level clear", pin, 1'b0);
      lvl = 1'b1;
      idle(3 * DIV);
      chk("R7 level survives pulse end", pin, 1'b0);
      chk("R8 busy cleared with level on", busy, 1'b0);
      lvl = 1'b0;
      idle(2);

      // random mix, checked every cycle against the model
      req = "R7 random";
      for (int i = 0; i < 4000; i++) begin
         go = ($urandom_range(0, 9) == 0);
         width = WB'($urandom_range(0, 6));
         if ($urandom_range(0, 15) == 0) lvl = ~lvl;
         if ($urandom_range(0, 63) == 0) act_high = ~act_high;
         @(negedge clk);
      end
      go = 1'b0;
      idle(40);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule